// File: doc/BRIEF.md
# Tag-Broadcast Reservation Station Scheduler

This block schedules instructions out of order for one shared arithmetic unit. Instructions come in program order through an issue port. Each one is placed in a free reservation station. At that point its source registers are renamed: a source whose value is not yet computed is replaced by the tag of the station that will produce it.

A station whose two operands are both present competes for the functional unit. Among the ready stations, the oldest in program order wins. Finished results go out on a single tagged result bus. Waiting stations and the register file take their values from that bus.

The register file has eight entries by default. After reset, register k holds the value k+1. A read port shows each register's value and whether a write to it is still outstanding.

Top module: `rs_sched`

## Requirements
- R1: After reset, every station is free (`iss_ready`=1), `cdb_valid`=0, register k reads k+1 and no register is pending.
- R2: Issue is in program order. When all stations are busy, `iss_ready` is 0 and an instruction presented with `iss_valid` is dropped with no effect on any register.
- R3: At issue, a source register with no pending writer is copied as a value. Otherwise the tag of its producer is stored, and the station waits for that tag.
- R4: At issue, the destination's pending tag is overwritten with the new station's tag (`iss_tag` = station index + 1, tag 0 means none), and `rd_pending` goes to 1.
- R5: When the bus carries a tag, every station waiting on that tag takes the value and clears the tag in that same cycle. The result carries the tag given to the instruction at issue.
- R6: A register is written from the bus only while its pending tag equals the bus tag, and its pending flag then clears. An older writer that finishes after a younger one (WAW) leaves the younger value.
- R7: At most one result is broadcast per cycle. Among ready stations, the oldest issued one is dispatched first.
- R8: For an independent instruction with the unit idle, `cdb_valid` is high in the cycle after the issue edge + LAT, where LAT is 2 for add/sub, 10 for multiply and 40 for divide. A dependent instruction broadcasts 3 cycles after its producer does, if the unit is idle.
- R9: A younger instruction whose operands are ready executes before an older one that is still waiting.
- R10: A source whose producer broadcasts in the same cycle as the issue takes the bus value directly.
- R11: Opcodes are 0 add, 1 sub (src1−src2), 2 multiply (low DATA_W bits), 3 divide (src1/src2). Divide by zero gives all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | Issue request |
| iss_ready | output | 1 | A station is free; an issue with iss_valid is accepted at the edge |
| iss_tag | output | TAG_W | Tag that the next accepted instruction receives |
| iss_op | input | 2 | Opcode |
| iss_src1 | input | RA_W | First source register |
| iss_src2 | input | RA_W | Second source register |
| iss_dst | input | RA_W | Destination register |
| cdb_valid | output | 1 | Result bus carries a result |
| cdb_tag | output | TAG_W | Tag of the producing station |
| cdb_data | output | DATA_W | Result value |
| rd_addr | input | RA_W | Register read address |
| rd_data | output | DATA_W | Register value |
| rd_pending | output | 1 | Register awaits a result |

## Verification
Take the issue edge as cycle 0. An independent result is on the bus LAT cycles later. A dependent one follows its producer by 3 cycles: capture, dispatch, then one cycle of execution for add. When the unit is busy, a waiting result follows the one before it by 2 cycles. Register contents change one edge after the broadcast. The directed tasks drive inputs on falling edges and count falling edges until `cdb_valid` is seen. Each count is compared with the exact cycle derived from these rules, and the bus tag and data are checked at that same sample point.

// File: rtl/rs_pkg.sv
// Shared opcode type for the reservation station scheduler.
package rs_pkg;
    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_MUL = 2'd2,
        OP_DIV = 2'd3
    } op_e;
endpackage

// File: rtl/rs_station.sv
// One reservation station: holds an issued operation, its operand values
// or producer tags, and snoops the result bus for missing operands.
// Assumes the top forwards same-cycle bus values into the issue inputs.
module rs_station
    import rs_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int TAG_W  = 3,
    parameter int SEQ_W  = 5,
    parameter int MY_TAG = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  op_e               op_in,
    input  logic [DATA_W-1:0] vj_in,
    input  logic [TAG_W-1:0]  qj_in,
    input  logic [DATA_W-1:0] vk_in,
    input  logic [TAG_W-1:0]  qk_in,
    input  logic [SEQ_W-1:0]  seq_in,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_data,
    input  logic              grant,
    output logic              busy,
    output logic              ready,
    output op_e               op,
    output logic [DATA_W-1:0] vj,
    output logic [DATA_W-1:0] vk,
    output logic [SEQ_W-1:0]  seq
);
    logic [TAG_W-1:0] qj, qk;
    logic             sent;
    logic             done;

    // This station's own result is on the bus
    assign done  = cdb_valid && (cdb_tag == TAG_W'(MY_TAG));
    // Both operands present and not yet dispatched
    assign ready = busy && !sent && (qj == '0) && (qk == '0);

    // Station state: allocate, dispatch, capture operands, free on broadcast
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            sent <= 1'b0;
            qj   <= '0;
            qk   <= '0;
            op   <= OP_ADD;
            vj   <= '0;
            vk   <= '0;
            seq  <= '0;
        end else if (alloc) begin
            busy <= 1'b1;
            sent <= 1'b0;
            op   <= op_in;
            vj   <= vj_in;
            qj   <= qj_in;
            vk   <= vk_in;
            qk   <= qk_in;
            seq  <= seq_in;
        end else begin
            if (grant) sent <= 1'b1;
            if (done) begin
                busy <= 1'b0;
                sent <= 1'b0;
            end
            if (busy && cdb_valid && qj != '0 && qj == cdb_tag) begin
                vj <= cdb_data;
                qj <= '0;
            end
            if (busy && cdb_valid && qk != '0 && qk == cdb_tag) begin
                vk <= cdb_data;
                qk <= '0;
            end
        end
    end

    // R5: a matching broadcast fills the operand on the next edge
    assert_capture_j_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && !alloc && cdb_valid && qj != '0 && qj == cdb_tag)
        |=> (qj == '0 && vj == $past(cdb_data)));
    assert_capture_k_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && !alloc && cdb_valid && qk != '0 && qk == cdb_tag)
        |=> (qk == '0 && vk == $past(cdb_data)));
    // R7: dispatch only of a ready station
    assert_grant_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> ready);
endmodule

// File: rtl/rs_arbiter.sv
// Oldest-first selector: grants the ready station with the lowest issue
// sequence number. Sequence numbers wrap; in-flight count must stay below
// half the sequence range.
module rs_arbiter #(
    parameter int NUM_RS = 4,
    parameter int SEQ_W  = 5
) (
    input  logic [NUM_RS-1:0]            ready,
    input  logic [NUM_RS-1:0][SEQ_W-1:0] seq,
    input  logic                         enable,
    output logic [NUM_RS-1:0]            grant
);
    function automatic logic is_older(input logic [SEQ_W-1:0] a,
                                      input logic [SEQ_W-1:0] b);
        logic [SEQ_W-1:0] diff;
        diff = a - b;
        return diff[SEQ_W-1];
    endfunction

    // Scan for the oldest ready station
    always_comb begin
        logic             found;
        int               best;
        logic [SEQ_W-1:0] best_seq;
        found    = 1'b0;
        best     = 0;
        best_seq = '0;
        for (int i = 0; i < NUM_RS; i++) begin
            if (ready[i] && (!found || is_older(seq[i], best_seq))) begin
                found    = 1'b1;
                best     = i;
                best_seq = seq[i];
            end
        end
        grant = '0;
        if (enable && found) grant[best] = 1'b1;
    end
endmodule

// File: rtl/rs_fu.sv
// Shared fixed-latency functional unit. Takes one operation when free,
// counts its latency down and presents the tagged result for one cycle.
module rs_fu
    import rs_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int TAG_W   = 3,
    parameter int LAT_ADD = 2,
    parameter int LAT_MUL = 10,
    parameter int LAT_DIV = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  op_e               op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [TAG_W-1:0]  tag,
    output logic              free,
    output logic              out_valid,
    output logic [TAG_W-1:0]  out_tag,
    output logic [DATA_W-1:0] out_data
);
    localparam int MAX_LAT = (LAT_DIV > LAT_MUL) ?
                             ((LAT_DIV > LAT_ADD) ? LAT_DIV : LAT_ADD) :
                             ((LAT_MUL > LAT_ADD) ? LAT_MUL : LAT_ADD);
    localparam int CNT_W = $clog2(MAX_LAT + 1);

    logic              busy;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  lat_m1;
    logic [DATA_W-1:0] result;

    assign out_valid = busy && (cnt == '0);
    assign free      = !busy || out_valid;

    // Result and latency selection for the incoming operation
    always_comb begin
        unique case (op)
            OP_ADD: begin result = a + b; lat_m1 = CNT_W'(LAT_ADD - 1); end
            OP_SUB: begin result = a - b; lat_m1 = CNT_W'(LAT_ADD - 1); end
            OP_MUL: begin result = a * b; lat_m1 = CNT_W'(LAT_MUL - 1); end
            default: begin
                result = (b == '0) ? '1 : a / b;
                lat_m1 = CNT_W'(LAT_DIV - 1);
            end
        endcase
    end

    // Execution countdown
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            cnt      <= '0;
            out_tag  <= '0;
            out_data <= '0;
        end else if (load) begin
            busy     <= 1'b1;
            cnt      <= lat_m1;
            out_tag  <= tag;
            out_data <= result;
        end else if (out_valid) begin
            busy <= 1'b0;
        end else if (busy) begin
            cnt <= cnt - 1'b1;
        end
    end

    // R8: latency counts down one per cycle while executing
    assert_countdown_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt != '0) |=> (busy && cnt == $past(cnt) - 1'b1));
    // R7: no new operation while one is still counting
    assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt != '0) |-> !load);
endmodule

// File: rtl/rs_sched.sv
// Reservation station scheduler top: register file with pending tags,
// in-order issue with renaming, station pool, oldest-first dispatch and
// the tagged result bus. Register k resets to k+1.
module rs_sched
    import rs_pkg::*;
#(
    parameter int NUM_RS   = 4,
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 16,
    parameter int LAT_ADD  = 2,
    parameter int LAT_MUL  = 10,
    parameter int LAT_DIV  = 40
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          iss_valid,
    output logic                          iss_ready,
    output logic [$clog2(NUM_RS+1)-1:0]   iss_tag,
    input  logic [1:0]                    iss_op,
    input  logic [$clog2(NUM_REGS)-1:0]   iss_src1,
    input  logic [$clog2(NUM_REGS)-1:0]   iss_src2,
    input  logic [$clog2(NUM_REGS)-1:0]   iss_dst,
    output logic                          cdb_valid,
    output logic [$clog2(NUM_RS+1)-1:0]   cdb_tag,
    output logic [DATA_W-1:0]             cdb_data,
    input  logic [$clog2(NUM_REGS)-1:0]   rd_addr,
    output logic [DATA_W-1:0]             rd_data,
    output logic                          rd_pending
);
    localparam int TAG_W = $clog2(NUM_RS + 1);
    localparam int SEQ_W = TAG_W + 2;

    logic [DATA_W-1:0] reg_val [NUM_REGS];
    logic [TAG_W-1:0]  reg_tag [NUM_REGS];
    logic [SEQ_W-1:0]  seq_ctr;

    logic [NUM_RS-1:0]            st_busy, st_ready, grant;
    logic [NUM_RS-1:0][SEQ_W-1:0] st_seq;
    op_e                          st_op [NUM_RS];
    logic [DATA_W-1:0]            st_vj [NUM_RS];
    logic [DATA_W-1:0]            st_vk [NUM_RS];

    logic              iss_fire;
    logic [TAG_W-1:0]  alloc_idx;
    logic [TAG_W-1:0]  s1_tag, s2_tag;
    logic [DATA_W-1:0] s1_val, s2_val;
    logic              fu_free, fu_load;
    op_e               d_op;
    logic [DATA_W-1:0] d_a, d_b;
    logic [TAG_W-1:0]  d_tag;

    assign iss_fire   = iss_valid && iss_ready;
    assign iss_tag    = alloc_idx + 1'b1;
    assign rd_data    = reg_val[rd_addr];
    assign rd_pending = (reg_tag[rd_addr] != '0);

    // Lowest-numbered free station receives the next issue
    always_comb begin
        alloc_idx = '0;
        iss_ready = 1'b0;
        for (int i = NUM_RS - 1; i >= 0; i--) begin
            if (!st_busy[i]) begin
                alloc_idx = TAG_W'(i);
                iss_ready = 1'b1;
            end
        end
    end

    // Source renaming with same-cycle bus forwarding
    always_comb begin
        s1_tag = reg_tag[iss_src1];
        s1_val = reg_val[iss_src1];
        if (s1_tag != '0 && cdb_valid && cdb_tag == s1_tag) begin
            s1_tag = '0;
            s1_val = cdb_data;
        end
        s2_tag = reg_tag[iss_src2];
        s2_val = reg_val[iss_src2];
        if (s2_tag != '0 && cdb_valid && cdb_tag == s2_tag) begin
            s2_tag = '0;
            s2_val = cdb_data;
        end
    end

    // Register file write-back and destination renaming
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                reg_val[i] <= DATA_W'(i + 1);
                reg_tag[i] <= '0;
            end
            seq_ctr <= '0;
        end else begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (cdb_valid && reg_tag[i] != '0 && reg_tag[i] == cdb_tag) begin
                    reg_val[i] <= cdb_data;
                    reg_tag[i] <= '0;
                end
                if (iss_fire && iss_dst == i[$clog2(NUM_REGS)-1:0])
                    reg_tag[i] <= iss_tag;
            end
            if (iss_fire) seq_ctr <= seq_ctr + 1'b1;
        end
    end

    for (genvar g = 0; g < NUM_RS; g++) begin : g_st
        rs_station #(
            .DATA_W(DATA_W), .TAG_W(TAG_W), .SEQ_W(SEQ_W), .MY_TAG(g + 1)
        ) u_st (
            .clk      (clk),
            .rst_n    (rst_n),
            .alloc    (iss_fire && alloc_idx == TAG_W'(g)),
            .op_in    (op_e'(iss_op)),
            .vj_in    (s1_val),
            .qj_in    (s1_tag),
            .vk_in    (s2_val),
            .qk_in    (s2_tag),
            .seq_in   (seq_ctr),
            .cdb_valid(cdb_valid),
            .cdb_tag  (cdb_tag),
            .cdb_data (cdb_data),
            .grant    (grant[g]),
            .busy     (st_busy[g]),
            .ready    (st_ready[g]),
            .op       (st_op[g]),
            .vj       (st_vj[g]),
            .vk       (st_vk[g]),
            .seq      (st_seq[g])
        );
    end

    rs_arbiter #(.NUM_RS(NUM_RS), .SEQ_W(SEQ_W)) u_arb (
        .ready (st_ready),
        .seq   (st_seq),
        .enable(fu_free),
        .grant (grant)
    );

    // Dispatch operand mux from the granted station
    always_comb begin
        d_op  = OP_ADD;
        d_a   = '0;
        d_b   = '0;
        d_tag = '0;
        for (int i = 0; i < NUM_RS; i++) begin
            if (grant[i]) begin
                d_op  = st_op[i];
                d_a   = st_vj[i];
                d_b   = st_vk[i];
                d_tag = TAG_W'(i + 1);
            end
        end
    end
    assign fu_load = |grant;

    rs_fu #(
        .DATA_W(DATA_W), .TAG_W(TAG_W),
        .LAT_ADD(LAT_ADD), .LAT_MUL(LAT_MUL), .LAT_DIV(LAT_DIV)
    ) u_fu (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (fu_load),
        .op       (d_op),
        .a        (d_a),
        .b        (d_b),
        .tag      (d_tag),
        .free     (fu_free),
        .out_valid(cdb_valid),
        .out_tag  (cdb_tag),
        .out_data (cdb_data)
    );

    // Busy flag of the station named on the bus
    logic owner_busy;
    always_comb begin
        owner_busy = 1'b0;
        for (int i = 0; i < NUM_RS; i++)
            if (cdb_tag == TAG_W'(i + 1)) owner_busy = st_busy[i];
    end

    // R7: one dispatch per cycle
    assert_one_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // R6: a broadcast comes from a live station
    assert_cdb_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cdb_valid |-> owner_busy);
    // R2: a stalled request does not advance program order
    assert_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_ready) |=> seq_ctr == $past(seq_ctr));

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_rchk
        // R6: a matching broadcast lands in the register and clears pending
        assert_writeback_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (cdb_valid && reg_tag[r] != '0 && reg_tag[r] == cdb_tag &&
             !(iss_fire && iss_dst == r[$clog2(NUM_REGS)-1:0]))
            |=> (reg_tag[r] == '0 && reg_val[r] == $past(cdb_data)));
    end
endmodule

// File: tb/rs_sched_tb.sv
module rs_sched_tb;
    localparam int TW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          iss_valid = 1'b0;
    logic          iss_ready;
    logic [TW-1:0] iss_tag;
    logic [1:0]    iss_op = '0;
    logic [2:0]    iss_src1 = '0, iss_src2 = '0, iss_dst = '0;
    logic          cdb_valid;
    logic [TW-1:0] cdb_tag;
    logic [15:0]   cdb_data;
    logic [2:0]    rd_addr = '0;
    logic [15:0]   rd_data;
    logic          rd_pending;

    int n_run = 0;
    int n_fail = 0;
    int cyc_total = 0;

    rs_sched u_dut (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
        .iss_tag(iss_tag), .iss_op(iss_op), .iss_src1(iss_src1),
        .iss_src2(iss_src2), .iss_dst(iss_dst), .cdb_valid(cdb_valid),
        .cdb_tag(cdb_tag), .cdb_data(cdb_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_pending(rd_pending)
    );

    always #5 clk = ~clk;

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        iss_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Presents one instruction at a falling edge; returns at the next falling edge
    task automatic issue(input int op, input int s1, input int s2, input int d,
                         output logic [TW-1:0] tag);
        iss_op = 2'(op); iss_src1 = 3'(s1); iss_src2 = 3'(s2); iss_dst = 3'(d);
        iss_valid = 1'b1;
        tag = iss_tag;
        @(posedge clk);
        @(negedge clk);
        iss_valid = 1'b0;
    endtask

    // Counts falling edges until the bus carries a result
    task automatic wait_cdb(output int cyc, output logic [TW-1:0] tag, output int data);
        cyc = 0; tag = '0; data = -1;
        for (int i = 1; i <= 100; i++) begin
            @(negedge clk);
            if (cdb_valid) begin
                cyc = i; tag = cdb_tag; data = int'(cdb_data);
                break;
            end
        end
    endtask

    task automatic chk_reg(input int r, input int val, input logic pend, input string req);
        rd_addr = 3'(r);
        #1;
        chk(rd_data == 16'(val), req, int'(rd_data), val);
        chk(rd_pending == pend, req, int'(rd_pending), int'(pend));
    endtask

    task automatic t_reset();
        do_reset();
        chk(iss_ready == 1'b1, "R1 ready", int'(iss_ready), 1);
        chk(cdb_valid == 1'b0, "R1 bus idle", int'(cdb_valid), 0);
        chk_reg(3, 4, 1'b0, "R1 reg3");
        chk_reg(0, 1, 1'b0, "R1 reg0");
    endtask

    task automatic t_add_sub();
        logic [TW-1:0] t, bt; int c, d;
        do_reset();
        issue(0, 2, 3, 1, t);
        chk_reg(1, 2, 1'b1, "R4 dst pending");
        wait_cdb(c, bt, d);
        chk(c == 2, "R8 add latency", c, 2);
        chk(d == 7, "R11 add", d, 7);
        chk(bt == t, "R5 tag", int'(bt), int'(t));
        @(negedge clk);
        chk_reg(1, 7, 1'b0, "R6 writeback");
        issue(1, 6, 2, 4, t);
        wait_cdb(c, bt, d);
        chk(c == 2 && d == 4, "R11 sub", d, 4);
    endtask

    task automatic t_mul_div();
        logic [TW-1:0] t, bt; int c, d;
        do_reset();
        issue(2, 2, 3, 5, t);
        wait_cdb(c, bt, d);
        chk(c == 10, "R8 mul latency", c, 10);
        chk(d == 12, "R11 mul", d, 12);
        issue(3, 5, 2, 6, t);
        wait_cdb(c, bt, d);
        chk(c == 40, "R8 div latency", c, 40);
        chk(d == 4, "R10 div forwarded", d, 4);
        issue(1, 2, 2, 7, t);
        wait_cdb(c, bt, d);
        chk(d == 0, "R11 zero", d, 0);
        issue(3, 3, 7, 0, t);
        wait_cdb(c, bt, d);
        chk(d == 16'hFFFF, "R11 div by zero", d, 16'hFFFF);
        @(negedge clk);
        chk_reg(0, 16'hFFFF, 1'b0, "R11 div reg");
    endtask

    task automatic t_chain();
        logic [TW-1:0] tm, ta, bt; int c, d;
        do_reset();
        issue(2, 2, 3, 1, tm);
        issue(0, 1, 2, 4, ta);
        chk_reg(4, 5, 1'b1, "R3 dependent pending");
        wait_cdb(c, bt, d);
        chk(c == 9 && bt == tm, "R3 producer first", c, 9);
        wait_cdb(c, bt, d);
        chk(c == 3, "R8 dependent spacing", c, 3);
        chk(d == 15 && bt == ta, "R5 captured operand", d, 15);
        @(negedge clk);
        chk_reg(4, 15, 1'b0, "R3 result");
    endtask

    task automatic t_waw_ooo();
        logic [TW-1:0] ta, tb, tc, bt; int c, d;
        do_reset();
        issue(2, 2, 3, 5, ta);
        issue(0, 5, 2, 1, tb);
        issue(1, 3, 2, 1, tc);
        wait_cdb(c, bt, d);
        chk(c == 8 && d == 12, "R8 mul first", d, 12);
        wait_cdb(c, bt, d);
        chk(bt == tc && d == 1, "R9 younger first", int'(bt), int'(tc));
        chk(c == 2, "R9 timing", c, 2);
        wait_cdb(c, bt, d);
        chk(bt == tb && d == 15, "R9 older later", d, 15);
        @(negedge clk);
        chk_reg(1, 1, 1'b0, "R6 WAW keeps younger");
        chk_reg(5, 12, 1'b0, "R6 reg5");
    endtask

    task automatic t_oldest_stall();
        logic [TW-1:0] t, bt; int c, d;
        do_reset();
        issue(2, 2, 3, 7, t);
        issue(0, 2, 3, 1, t);
        issue(1, 3, 2, 4, t);
        issue(0, 2, 2, 6, t);
        chk(iss_ready == 1'b0, "R2 full", int'(iss_ready), 0);
        issue(0, 3, 3, 0, t);
        wait_cdb(c, bt, d);
        chk(c == 6 && d == 12, "R7 mul", d, 12);
        wait_cdb(c, bt, d);
        chk(c == 2 && d == 7, "R7 oldest add", d, 7);
        wait_cdb(c, bt, d);
        chk(c == 2 && d == 1, "R7 then sub", d, 1);
        wait_cdb(c, bt, d);
        chk(c == 2 && d == 6, "R7 then add", d, 6);
        @(negedge clk);
        chk_reg(0, 1, 1'b0, "R2 dropped issue");
        chk(iss_ready == 1'b1, "R2 freed", int'(iss_ready), 1);
    endtask

    task automatic t_forward();
        logic [TW-1:0] t, bt; int c, d;
        do_reset();
        issue(0, 2, 3, 1, t);
        @(negedge clk);
        @(negedge clk);
        chk(cdb_valid == 1'b1 && cdb_tag == t, "R10 producer on bus", int'(cdb_valid), 1);
        issue(0, 1, 1, 4, t);
        wait_cdb(c, bt, d);
        chk(c == 2, "R10 timing", c, 2);
        chk(d == 14, "R10 forwarded value", d, 14);
    endtask

    initial begin
        t_reset();
        t_add_sub();
        t_mul_div();
        t_chain();
        t_waw_ooo();
        t_oldest_stall();
        t_forward();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog
    always @(posedge clk) begin
        cyc_total++;
        if (cyc_total > 20000) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc_total, 20000);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule